// File: doc/BRIEF.md
# Peak Level Meter with Half-Decibel Log Converter

This block turns a stream of signed 18-bit PCM samples into a 7-bit level code for a bargraph. Every valid sample is rectified, and the largest magnitude seen is kept in a peak register. A periodic decay tick, normally driven at the display frame rate, shrinks the held peak by a fixed fraction below one, so an idle meter falls off smoothly on a logarithmic scale.

When a conversion is requested, the held peak is captured and a small sequential engine turns it into an attenuation code in half-decibel steps. It first shifts the value left until its top bit is set, charging 12 codes (about 6 dB) per shift. It then compares the 8-bit mantissa against a table of fine thresholds spaced 0.5 dB apart. The result is a monotonic code from 0 (full scale) to 127 (-63.5 dB or quieter), with no missing codes, and it is flagged by a one-cycle done pulse. A display controller reads the code after each pulse and asks for a new one once per frame.

Top module: `peak_log_meter`

## Requirements
- R1: The magnitude of a sample is its absolute value on 17 bits; the most negative input -131072 gives 131071.
- R2: While `pcm_valid_i` is high, the held peak is replaced by the sample magnitude if that magnitude is strictly larger. Without a decay tick, the held peak never falls.
- R3: On a cycle with `decay_tick_i` high, the held peak becomes P - floor(P / 2^DECAY_SHIFT), with a default DECAY_SHIFT of 3. A valid sample in the same cycle is compared against that decayed value.
- R4: After synchronous reset, the held peak is 0, `busy_o` and `code_valid_o` are low, and `level_code_o` is 127.
- R5: A conversion uses the held peak as it stands on the clock edge that accepts `conv_start_i`. Later samples do not change that result.
- R6: For a nonzero value with its highest set bit at index p (0..16), the coarse part of the code is 12*(16-p).
- R7: After normalisation, the mantissa m is bits 16..9 of the shifted value. The fine part is the number of thresholds among 242, 228, 215, 204, 192, 182, 172, 162, 153, 144, 136 that are strictly greater than m (0..11). The unused first entry, 256, stands for 1.0.
- R8: The code is coarse plus fine, clamped to 127. A held value of 0 gives 127.
- R9: Over decreasing input magnitudes, the code never decreases. Where magnitudes fall in steps under 0.5 dB, the code never rises by more than 1.
- R10: `code_valid_o` pulses high for exactly one cycle, at most 18 cycles after the start edge. `busy_o` is high in between and low when the pulse appears.
- R11: A `conv_start_i` while `busy_o` is high is ignored: it produces no second result and does not restart the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pcm_valid_i | input | 1 | Sample strobe |
| pcm_sample_i | input | 18 | Signed PCM sample |
| decay_tick_i | input | 1 | Periodic decay strobe |
| conv_start_i | input | 1 | Conversion request |
| peak_level_o | output | 17 | Current held peak magnitude |
| level_code_o | output | 7 | Last attenuation code, in 0.5 dB per step |
| code_valid_o | output | 1 | One-cycle pulse when a new code is ready |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions take for granted that reset is held for at least one clock before any stimulus, and that `conv_start_i` is a clean, synchronous level, whether or not it arrives while busy. They also assume the decay tick and sample strobe may coincide, but that the sample input is only meaningful when its strobe is high. The stimulus changes every input on the falling edge only and pulses start and tick for single cycles. It deliberately raises start during a conversion, to exercise the ignore path inside those assumptions.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int PCM_W      = 18;
    localparam int MAG_W      = PCM_W - 1;
    localparam int MAG_MSB    = MAG_W - 1;
    localparam int CODE_W     = 7;
    localparam int MANT_W     = 8;
    localparam int FINE_N     = 12;
    localparam int FINE_W     = $clog2(FINE_N);
    localparam int SHIFT_W    = $clog2(MAG_W) + 1;
    localparam int SUM_W      = 9;
    localparam int CODE_MAX   = (1 << CODE_W) - 1;
    localparam int STEP_SHIFT = FINE_N;   // codes charged per one-bit shift

    typedef logic [MAG_W-1:0]  mag_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [MANT_W-1:0] mant_t;
    typedef logic [FINE_W-1:0] fine_t;

    typedef enum logic [0:0] {
        CV_IDLE = 1'b0,
        CV_NORM = 1'b1
    } cv_state_e;

    typedef struct packed {
        mag_t                 work;
        logic [SHIFT_W-1:0]   shifts;
    } norm_t;

    // Half-dB threshold ladder on an 8-bit mantissa scale (256 == 1.0).
    function automatic logic [MANT_W:0] fine_thr(input int k);
        logic [MANT_W:0] t;
        case (k)
            0:  t = 9'd256;
            1:  t = 9'd242;
            2:  t = 9'd228;
            3:  t = 9'd215;
            4:  t = 9'd204;
            5:  t = 9'd192;
            6:  t = 9'd182;
            7:  t = 9'd172;
            8:  t = 9'd162;
            9:  t = 9'd153;
            10: t = 9'd144;
            11: t = 9'd136;
            default: t = 9'd0;
        endcase
        return t;
    endfunction

    // Absolute value on MAG_W bits, saturating the most negative input.
    function automatic mag_t rectify(input logic signed [PCM_W-1:0] x);
        logic [PCM_W-1:0] a;
        a = x[PCM_W-1] ? (~x + 1'b1) : x;
        if (a[PCM_W-1])
            return {MAG_W{1'b1}};
        return a[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/plm_peak_hold.sv
module plm_peak_hold
    import plm_pkg::*;
#(
    parameter int DECAY_SHIFT = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic signed [PCM_W-1:0] sample,
    input  logic                    decay_tick,
    output mag_t                    held_o
);

    mag_t held_q;
    mag_t mag;
    mag_t decayed;
    mag_t base;
    mag_t held_d;

    always_comb begin
        mag     = rectify(sample);
        decayed = held_q - (held_q >> DECAY_SHIFT);
        base    = decay_tick ? decayed : held_q;
        held_d  = (sample_valid && (mag > base)) ? mag : base;
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= held_d;
    end

    assign held_o = held_q;

    // R2: without a tick the peak cannot fall
    a_r2_no_fall: assert property (@(posedge clk) disable iff (rst)
        !decay_tick |=> (held_q >= $past(held_q)));

    // R3: a tick with no sample never raises the peak
    a_r3_decay_down: assert property (@(posedge clk) disable iff (rst)
        (decay_tick && !sample_valid) |=> (held_q <= $past(held_q)));

    // R1: most negative sample saturates to full magnitude
    a_r1_min_sat: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && sample == {1'b1, {MAG_W{1'b0}}}) |=> (held_q == {MAG_W{1'b1}}));

endmodule

// File: rtl/plm_fine_cmp.sv
module plm_fine_cmp
    import plm_pkg::*;
(
    input  mant_t mant,
    output fine_t fine
);

    logic [FINE_N-2:0] below;

    for (genvar k = 1; k < FINE_N; k++) begin : g_thr
        assign below[k-1] = ({1'b0, mant} < fine_thr(k));
    end

    always_comb begin
        fine = '0;
        for (int i = 0; i < FINE_N - 1; i++)
            fine = fine + fine_t'(below[i]);
    end

endmodule

// File: rtl/plm_log_fsm.sv
module plm_log_fsm
    import plm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  mag_t  held,
    input  fine_t fine,
    output mant_t mant,
    output logic  busy,
    output logic  done,
    output code_t code
);

    cv_state_e        state_q;
    norm_t            nrm_q;
    logic             done_q;
    code_t            code_q;
    logic [SUM_W-1:0] total;
    code_t            clamped;

    assign mant = nrm_q.work[MAG_MSB -: MANT_W];

    always_comb begin
        total   = SUM_W'(nrm_q.shifts) * SUM_W'(STEP_SHIFT) + SUM_W'(fine);
        clamped = (total > SUM_W'(CODE_MAX)) ? code_t'(CODE_MAX) : total[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CV_IDLE;
            nrm_q   <= '0;
            done_q  <= 1'b0;
            code_q  <= code_t'(CODE_MAX);
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CV_IDLE: begin
                    if (start) begin
                        nrm_q.work   <= held;
                        nrm_q.shifts <= '0;
                        state_q      <= CV_NORM;
                    end
                end
                CV_NORM: begin
                    if (nrm_q.work == '0) begin
                        code_q  <= code_t'(CODE_MAX);
                        done_q  <= 1'b1;
                        state_q <= CV_IDLE;
                    end else if (nrm_q.work[MAG_MSB]) begin
                        code_q  <= clamped;
                        done_q  <= 1'b1;
                        state_q <= CV_IDLE;
                    end else begin
                        nrm_q.work   <= nrm_q.work << 1;
                        nrm_q.shifts <= nrm_q.shifts + 1'b1;
                    end
                end
                default: state_q <= CV_IDLE;
            endcase
        end
    end

    assign busy = (state_q != CV_IDLE);
    assign done = done_q;
    assign code = code_q;

    // R10: result strobe is a single cycle
    a_r10_one_shot: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: busy has dropped when the result appears
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);

    // R6: each normalising step charges exactly one shift
    a_r6_shift_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == CV_NORM && nrm_q.work != '0 && !nrm_q.work[MAG_MSB])
        |=> (nrm_q.shifts == $past(nrm_q.shifts) + 1'b1));

    // R8: an empty value resolves to the floor code
    a_r8_zero_floor: assert property (@(posedge clk) disable iff (rst)
        (state_q == CV_NORM && nrm_q.work == '0) |=> (done_q && code_q == code_t'(CODE_MAX)));

    // R11: a request during a conversion does not reload the work value
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == CV_NORM && start && nrm_q.work != '0 && !nrm_q.work[MAG_MSB])
        |=> (nrm_q.work == ($past(nrm_q.work) << 1)));

endmodule

// File: rtl/peak_log_meter.sv
module peak_log_meter
    import plm_pkg::*;
#(
    parameter int DECAY_SHIFT = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pcm_valid_i,
    input  logic signed [PCM_W-1:0] pcm_sample_i,
    input  logic                    decay_tick_i,
    input  logic                    conv_start_i,
    output logic [MAG_W-1:0]        peak_level_o,
    output logic [CODE_W-1:0]       level_code_o,
    output logic                    code_valid_o,
    output logic                    busy_o
);

    mag_t  held;
    mant_t mant;
    fine_t fine;

    plm_peak_hold #(.DECAY_SHIFT(DECAY_SHIFT)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (pcm_valid_i),
        .sample       (pcm_sample_i),
        .decay_tick   (decay_tick_i),
        .held_o       (held)
    );

    plm_fine_cmp u_fine (
        .mant (mant),
        .fine (fine)
    );

    plm_log_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (conv_start_i),
        .held  (held),
        .fine  (fine),
        .mant  (mant),
        .busy  (busy_o),
        .done  (code_valid_o),
        .code  (level_code_o)
    );

    assign peak_level_o = held;

endmodule

// File: tb/peak_log_meter_tb.sv
module peak_log_meter_tb_top;

    localparam int CLK_P = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pcm_valid = 1'b0;
    logic signed [17:0] pcm = '0;
    logic               tick = 1'b0;
    logic               start = 1'b0;
    logic [16:0]        peak;
    logic [6:0]         code;
    logic               cvalid;
    logic               busy;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    peak_log_meter dut_i (
        .clk          (clk),
        .rst          (rst),
        .pcm_valid_i  (pcm_valid),
        .pcm_sample_i (pcm),
        .decay_tick_i (tick),
        .conv_start_i (start),
        .peak_level_o (peak),
        .level_code_o (code),
        .code_valid_o (cvalid),
        .busy_o       (busy)
    );

    int thr [12] = '{256, 242, 228, 215, 204, 192, 182, 172, 162, 153, 144, 136};

    function automatic int ref_code(input int v);
        int p, s, m, f, c;
        if (v == 0) return 127;
        p = 0;
        for (int b = 0; b < 17; b++) if ((v >> b) & 1) p = b;
        s = 16 - p;
        m = ((v << s) >> 9) & 255;
        f = 0;
        for (int k = 1; k < 12; k++) if (m < thr[k]) f++;
        c = 12 * s + f;
        return (c > 127) ? 127 : c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pcm_valid = 1'b0; tick = 1'b0; start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(input int v);
        pcm_valid = 1'b1; pcm = 18'(v);
        @(negedge clk);
        pcm_valid = 1'b0;
    endtask

    task automatic convert(output int c, output int lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!cvalid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        c = int'(code);
    endtask

    task automatic t_reset();
        do_reset();
        check("R4 peak", int'(peak), 0);
        check("R4 busy", int'(busy), 0);
        check("R4 valid", int'(cvalid), 0);
        check("R4 code", int'(code), 127);
    endtask

    task automatic t_rectify();
        do_reset();
        feed(-5000);
        check("R1 neg magnitude", int'(peak), 5000);
        feed(-131072);
        check("R1 min saturates", int'(peak), 131071);
    endtask

    task automatic t_hold();
        do_reset();
        feed(3000);
        feed(-7000);
        check("R2 larger replaces", int'(peak), 7000);
        feed(6999);
        feed(-2);
        check("R2 smaller ignored", int'(peak), 7000);
        pcm = 18'sd100000;
        @(negedge clk);
        check("R2 no strobe ignored", int'(peak), 7000);
    endtask

    task automatic t_decay();
        do_reset();
        feed(100000);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R3 decay step", int'(peak), 87500);
        tick = 1'b1; pcm_valid = 1'b1; pcm = 18'sd90000;
        @(negedge clk);
        check("R3 tick with larger sample", int'(peak), 90000);
        pcm = 18'sd50000;
        @(negedge clk);
        tick = 1'b0; pcm_valid = 1'b0;
        check("R3 tick with smaller sample", int'(peak), 78750);
    endtask

    task automatic point(input string req, input int v);
        int c, lat;
        do_reset();
        feed(v);
        convert(c, lat);
        check({req, " code"}, c, ref_code(v));
        check("R10 latency", int'(lat <= 18), 1);
    endtask

    task automatic t_corners();
        point("R6 full scale", 131071);
        point("R6 top bit only", 65536);
        point("R6 just below bit", 65535);
        point("R7 at threshold", 242 << 9);
        point("R7 below threshold", 241 << 9);
        point("R7 bottom mantissa", 128 << 9);
        point("R8 clamp small", 1);
        point("R8 shifted mid", 1024);
        check("R6 65536 is 11", ref_code(65536), 11);
        check("R6 65535 is 12", ref_code(65535), 12);
        do_reset();
        begin
            int c, lat;
            convert(c, lat);
            check("R8 zero", c, 127);
        end
    endtask

    task automatic t_pulse();
        int c, lat, extra;
        do_reset();
        feed(300);
        convert(c, lat);
        check("R10 busy low at done", int'(busy), 0);
        @(negedge clk);
        check("R10 single pulse", int'(cvalid), 0);
        check("R10 code kept", int'(code), ref_code(300));
    endtask

    task automatic t_busy_ignore();
        int c, lat, extra;
        do_reset();
        feed(1024);
        start = 1'b1;
        @(negedge clk);
        check("R10 busy while converting", int'(busy), 1);
        pcm_valid = 1'b1; pcm = 18'sd131071;
        @(negedge clk);
        pcm_valid = 1'b0; start = 1'b0;
        lat = 2;
        while (!cvalid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R5 latched value", int'(code), 83);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cvalid) extra++;
        end
        check("R11 no second result", extra, 0);
        convert(c, lat);
        check("R5 new request sees new peak", c, 0);
    endtask

    task automatic t_ladder();
        int v, c, lat, prev, first;
        v = 131071;
        prev = -1;
        first = 1;
        while (v > 0) begin
            do_reset();
            feed(v);
            convert(c, lat);
            check("R9 ladder code", c, ref_code(v));
            if (first) check("R9 ladder starts at 0", c, 0);
            else begin
                check("R9 monotonic", int'(c >= prev), 1);
                if (v >= 512) check("R9 no missing code", int'(c - prev <= 1), 1);
            end
            first = 0;
            prev = c;
            v = v - (v >> 5) - 1;
        end
        check("R9 ladder ends at floor", prev, 127);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rectify();
        t_hold();
        t_decay();
        t_corners();
        t_pulse();
        t_busy_ignore();
        t_ladder();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule